// File: doc/BRIEF.md
# I2C Slave Address Recognition Front End

This block sits at the bus side of an I2C target. It watches the clock and data lines, which are already synchronised to the system clock. It detects START, repeated START and STOP conditions. After every START it collects the first byte, most significant bit first, and decides whether the transfer is meant for this device.

Three addresses are recognised in parallel:
- a fixed boot address that can never be changed;
- a programmable 7-bit address held in a small register;
- the general-call address, which is recognised only when software enables it.

On a match the block answers on the ninth clock with ACK or NACK, as chosen by a software bit. It stores the direction bit and raises a sticky match flag. It then parks in a transmit or receive state, where later data logic takes over. If the address does not match, the block stays silent and falls back to idle.

Software sees sticky flags for start, stop and match, which it clears by writing ones to a clear strobe. It also sees two busy indications and the latched direction. The data line is open drain: the block never drives it high. It only asserts a pull-low enable, and it shows by a separate output when it owns the line for transmission.

Top module: `i2c_addr_front`

## Requirements
- R1: After reset the phase output reads idle (code 0). The pull-low enable, the line-ownership output, all three flags, both busy outputs and the direction bit read 0. The address register reads 1Bh.
- R2: A falling data edge while the clock stays high (START or repeated START) has four effects, from any phase:
  - the start flag (flag bit 0) is set;
  - controller-busy and bus-busy are set;
  - the phase moves to address collection (code 1);
  - a repeated START does not change the latched direction bit.
- R3: A rising data edge while the clock stays high (STOP) has four effects:
  - the stop flag (flag bit 1) is set;
  - bus-busy and controller-busy are cleared;
  - the phase returns to idle;
  - the pull-low enable is released.
- R4: Address bits are sampled on rising clock edges, most significant first. The eighth bit is the direction, where 1 means the target transmits. At the falling clock edge that ends the eighth bit, an address equal to the register contents has four effects:
  - the phase moves to acknowledge (code 2);
  - the match flag (flag bit 2) is set;
  - the direction bit is latched;
  - controller-busy is cleared.
- R5: The boot address 1Ah (byte 34h or 35h on the bus) is matched at all times, including after the address register has been rewritten.
- R6: Address 00h is matched only while the general-call enable is 1. With the enable at 0 it is treated as a mismatch.
- R7: During the acknowledge phase the pull-low enable equals the ACK control input: 1 gives ACK (the data line is low on the ninth clock), 0 gives NACK (the line is left high). It is never asserted in any other phase.
- R8: At the falling edge that ends the ninth clock, the pull-low enable is released and the block leaves the acknowledge phase:
  - a latched direction of 1 selects transmit (code 3) with line ownership asserted;
  - a direction of 0 selects receive (code 4) with the line released.
- R9: On a mismatch the line is not pulled and the phase returns to idle. The match flag stays clear, controller-busy clears, and bus-busy stays set.
- R10: Flags stay set until software writes 1 to the matching bit of the clear strobe (bit 0 start, bit 1 stop, bit 2 match).
- R11: A START arriving partway through the address byte discards the bits collected so far. The next eight bits form a fresh address.
- R12: A one-cycle write strobe loads the address register. The new value shows on the register output and is used for every later comparison, and the old programmable address then mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| sda_own_o | output | 1 | Block owns the data line for transmit |
| addr_we_i | input | 1 | Write strobe for the address register |
| addr_wdata_i | input | 7 | New 7-bit address |
| addr_q_o | output | 7 | Current programmable address |
| gc_en_i | input | 1 | Enables general-call recognition |
| ack_en_i | input | 1 | 1 answers a match with ACK, 0 with NACK |
| flag_clr_i | input | 3 | Write-one-to-clear strobe for the start, stop and match flags |
| flag_start_o | output | 1 | Sticky START seen |
| flag_stop_o | output | 1 | Sticky STOP seen |
| flag_match_o | output | 1 | Sticky address matched |
| ctl_busy_o | output | 1 | Address phase in progress |
| bus_busy_o | output | 1 | Bus held between START and STOP |
| dir_o | output | 1 | Latched direction bit of the last match |
| phase_o | output | 3 | Phase code: 0 idle, 1 address, 2 acknowledge, 3 transmit, 4 receive |

## Verification
Each line condition is decoded in the same cycle that the input changes, from the new level and the level registered at the previous edge. Flags, busy bits, phase and the pull-low enable are therefore all valid one clock edge after the line event that causes them. A register write is visible one edge after its strobe. The bench holds every bus level for four clocks and queues its expectation only after that hold. This leaves at least three edges of slack past the single edge of latency. Outputs are compared at a falling clock edge, away from the edge where they change.

// File: rtl/i2c_af_pkg.sv
`timescale 1ns/1ps
package i2c_af_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int N_FLAGS = 3;
  localparam int FLG_START = 0;
  localparam int FLG_STOP = 1;
  localparam int FLG_MATCH = 2;
  localparam logic [ADDR_W-1:0] BOOT_ADDR_DEF = 7'h1A;
  localparam logic [ADDR_W-1:0] RESET_ADDR_DEF = 7'h1B;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_ACK  = 3'd2,
    PH_TX   = 3'd3,
    PH_RX   = 3'd4
  } phase_e;
endpackage

// File: rtl/i2c_af_cond_det.sv
`timescale 1ns/1ps
// Line condition decoder: compares present line levels with the levels
// registered at the previous edge.
module i2c_af_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise_o = scl_i & ~scl_q;
    scl_fall_o = ~scl_i & scl_q;
    start_o    = scl_i & scl_q & sda_q & ~sda_i;
    stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_af_shift.sv
`timescale 1ns/1ps
// Serial-in byte collector with bit counter.
module i2c_af_shift #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [BITS-1:0] data_o,
  output logic            full_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(BITS);

  logic [BITS-1:0] data_q, data_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      data_d = '0;
      cnt_d  = '0;
    end else if (shift_i && (cnt_q != CNT_FULL)) begin
      data_d = {data_q[BITS-2:0], bit_i};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign data_o = data_q;
  assign full_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/i2c_af_match.sv
`timescale 1ns/1ps
// Parallel comparison of the received address against every recognised slot.
module i2c_af_match #(
  parameter int AW = 7,
  parameter logic [AW-1:0] BOOT = 7'h1A
) (
  input  logic [AW-1:0] rx_addr_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic          gc_en_i,
  output logic          hit_o
);
  localparam int NSLOT = 3;

  logic [AW-1:0]    slot_addr [NSLOT];
  logic [NSLOT-1:0] slot_en;
  logic [NSLOT-1:0] slot_hit;

  always_comb begin
    slot_addr[0] = BOOT;
    slot_en[0]   = 1'b1;
    slot_addr[1] = prog_addr_i;
    slot_en[1]   = 1'b1;
    slot_addr[2] = '0;
    slot_en[2]   = gc_en_i;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_hit[g] = slot_en[g] && (rx_addr_i == slot_addr[g]);
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/i2c_af_status.sv
`timescale 1ns/1ps
// Sticky flags: set has priority over a simultaneous write-one clear.
module i2c_af_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar f = 0; f < N; f++) begin : g_flag
    logic q, d;
    always_comb begin
      d = q;
      if (set_i[f])      d = 1'b1;
      else if (clr_i[f]) d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flag_o[f] = q;
  end
endmodule

// File: rtl/i2c_addr_front.sv
`timescale 1ns/1ps
module i2c_addr_front
  import i2c_af_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_ADDR  = BOOT_ADDR_DEF,
  parameter logic [ADDR_W-1:0] RESET_ADDR = RESET_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              sda_own_o,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  output logic [ADDR_W-1:0] addr_q_o,
  input  logic              gc_en_i,
  input  logic              ack_en_i,
  input  logic [N_FLAGS-1:0] flag_clr_i,
  output logic              flag_start_o,
  output logic              flag_stop_o,
  output logic              flag_match_o,
  output logic              ctl_busy_o,
  output logic              bus_busy_o,
  output logic              dir_o,
  output logic [2:0]        phase_o
);
  // reset: asserted asynchronously, released after two clock edges
  logic rst_s1_n, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_s_n  <= rst_s1_n;
    end
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic sh_clr, sh_shift, sh_full;
  logic [BYTE_W-1:0] sh_byte;
  logic addr_hit;
  logic [N_FLAGS-1:0] flag_set, flags;

  phase_e ph_q, ph_d;
  logic   pull_q, pull_d;
  logic   dir_q, dir_d;
  logic   cbusy_q, cbusy_d;
  logic   bbusy_q, bbusy_d;
  logic   match_set;
  logic [ADDR_W-1:0] addr_reg_q, addr_reg_d;

  i2c_af_cond_det u_cond (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  i2c_af_shift #(.BITS(BYTE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr_i  (sh_clr),
    .shift_i(sh_shift),
    .bit_i  (sda_i),
    .data_o (sh_byte),
    .full_o (sh_full)
  );

  i2c_af_match #(.AW(ADDR_W), .BOOT(BOOT_ADDR)) u_match (
    .rx_addr_i  (sh_byte[BYTE_W-1:1]),
    .prog_addr_i(addr_reg_q),
    .gc_en_i    (gc_en_i),
    .hit_o      (addr_hit)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_START] = start_ev;
    flag_set[FLG_STOP]  = stop_ev;
    flag_set[FLG_MATCH] = match_set;
  end

  i2c_af_status #(.N(N_FLAGS)) u_status (
    .clk   (clk),
    .rst_n (rst_s_n),
    .set_i (flag_set),
    .clr_i (flag_clr_i),
    .flag_o(flags)
  );

  // address register next state
  always_comb begin
    addr_reg_d = addr_reg_q;
    if (addr_we_i) addr_reg_d = addr_wdata_i;
  end

  // phase control next state
  always_comb begin
    ph_d      = ph_q;
    pull_d    = pull_q;
    dir_d     = dir_q;
    cbusy_d   = cbusy_q;
    bbusy_d   = bbusy_q;
    match_set = 1'b0;
    sh_clr    = 1'b0;
    sh_shift  = 1'b0;
    if (start_ev) begin
      ph_d    = PH_ADDR;
      pull_d  = 1'b0;
      sh_clr  = 1'b1;
      cbusy_d = 1'b1;
      bbusy_d = 1'b1;
    end else if (stop_ev) begin
      ph_d    = PH_IDLE;
      pull_d  = 1'b0;
      cbusy_d = 1'b0;
      bbusy_d = 1'b0;
    end else begin
      unique case (ph_q)
        PH_ADDR: begin
          sh_shift = scl_rise;
          if (scl_fall && sh_full) begin
            cbusy_d = 1'b0;
            if (addr_hit) begin
              ph_d      = PH_ACK;
              pull_d    = ack_en_i;
              dir_d     = sh_byte[0];
              match_set = 1'b1;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            ph_d   = dir_q ? PH_TX : PH_RX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q       <= PH_IDLE;
      pull_q     <= 1'b0;
      dir_q      <= 1'b0;
      cbusy_q    <= 1'b0;
      bbusy_q    <= 1'b0;
      addr_reg_q <= RESET_ADDR;
    end else begin
      ph_q       <= ph_d;
      pull_q     <= pull_d;
      dir_q      <= dir_d;
      cbusy_q    <= cbusy_d;
      bbusy_q    <= bbusy_d;
      addr_reg_q <= addr_reg_d;
    end
  end

  assign sda_pull_o   = pull_q;
  assign sda_own_o    = (ph_q == PH_TX);
  assign addr_q_o     = addr_reg_q;
  assign flag_start_o = flags[FLG_START];
  assign flag_stop_o  = flags[FLG_STOP];
  assign flag_match_o = flags[FLG_MATCH];
  assign ctl_busy_o   = cbusy_q;
  assign bus_busy_o   = bbusy_q;
  assign dir_o        = dir_q;
  assign phase_o      = ph_q;
endmodule

// File: rtl/i2c_addr_front_chk.sv
`timescale 1ns/1ps
module i2c_addr_front_chk (
  input logic       clk,
  input logic       rst_s_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_pull_o,
  input logic       sda_own_o,
  input logic       flag_start_o,
  input logic       flag_match_o,
  input logic       ctl_busy_o,
  input logic       bus_busy_o,
  input logic [2:0] phase_o
);
  // line event seen at the pins leads to the start flag one edge later
  assert_start_flag_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> flag_start_o);

  assert_addr_busy_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase_o == 3'd1) |-> (ctl_busy_o && bus_busy_o));

  assert_stop_frees_bus_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> (!bus_busy_o && phase_o == 3'd0));

  assert_match_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(flag_match_o) |-> (phase_o == 3'd2));

  assert_pull_only_ack_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    sda_pull_o |-> (phase_o == 3'd2));

  assert_own_no_pull_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    sda_own_o |-> !sda_pull_o);

  assert_idle_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase_o == 3'd0) |-> !ctl_busy_o);
endmodule

bind i2c_addr_front i2c_addr_front_chk u_chk (
  .clk         (clk),
  .rst_s_n     (rst_s_n),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .sda_pull_o  (sda_pull_o),
  .sda_own_o   (sda_own_o),
  .flag_start_o(flag_start_o),
  .flag_match_o(flag_match_o),
  .ctl_busy_o  (ctl_busy_o),
  .bus_busy_o  (bus_busy_o),
  .phase_o     (phase_o)
);

// File: tb/sim_i2c_addr_front.sv
`timescale 1ns/1ps
module sim_i2c_addr_front;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic host_scl, host_sda;
  logic sda_bus;
  logic sda_pull, sda_own;
  logic addr_we;
  logic [6:0] addr_wdata, addr_q;
  logic gc_en, ack_en;
  logic [2:0] flag_clr;
  logic f_start, f_stop, f_match, cbusy, bbusy, dir;
  logic [2:0] phase;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  assign sda_bus = host_sda & ~sda_pull;

  i2c_addr_front u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .sda_own_o(sda_own),
    .addr_we_i(addr_we), .addr_wdata_i(addr_wdata), .addr_q_o(addr_q),
    .gc_en_i(gc_en), .ack_en_i(ack_en), .flag_clr_i(flag_clr),
    .flag_start_o(f_start), .flag_stop_o(f_stop), .flag_match_o(f_match),
    .ctl_busy_o(cbusy), .bus_busy_o(bbusy), .dir_o(dir), .phase_o(phase)
  );

  typedef struct packed {
    logic [2:0] ph;
    logic pull, own, fs, fp, fm, cb, bb, dr;
    logic [6:0] adr;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];

  // monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      obs_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{phase, sda_pull, sda_own, f_start, f_stop, f_match, cbusy, bbusy, dir, addr_q};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic chk(input string t, input logic [2:0] ph, input logic pull, own,
                     fs, fp, fm, cb, bb, dr, input logic [6:0] adr);
    @(posedge clk);
    exp_q.push_back('{ph, pull, own, fs, fp, fm, cb, bb, dr, adr});
    tag_q.push_back(t);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_val(input string t, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", t, act, expv);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; hold();
    host_scl = 1'b1; hold();
    host_sda = 1'b0; hold();
    host_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; hold();
    host_scl = 1'b1; hold();
    host_sda = 1'b1; hold();
  endtask

  task automatic bus_bit(input logic b);
    host_sda = b;    hold();
    host_scl = 1'b1; hold();
    host_scl = 1'b0; hold();
  endtask

  task automatic bus_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
  endtask

  task automatic ninth(output logic seen);
    host_sda = 1'b1; hold();
    host_scl = 1'b1; hold();
    seen = sda_bus;
    host_scl = 1'b0; hold();
  endtask

  task automatic clr_all();
    @(negedge clk) flag_clr = 3'b111;
    @(negedge clk) flag_clr = 3'b000;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic s;
    rst_n = 1'b0; host_scl = 1'b1; host_sda = 1'b1;
    addr_we = 1'b0; addr_wdata = '0; gc_en = 1'b0; ack_en = 1'b1; flag_clr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1 reset", 3'd0, 0,0, 0,0,0, 0,0,0, 7'h1B);

    // programmed address, write, ACK
    bus_start();
    chk("R2 start", 3'd1, 0,0, 1,0,0, 1,1,0, 7'h1B);
    clr_all();
    bus_byte(8'h36);
    chk("R4 R7 match ack", 3'd2, 1,0, 0,0,1, 0,1,0, 7'h1B);
    ninth(s);
    chk_val("R7 ack low on ninth", s, 1'b0);
    chk("R8 receive", 3'd4, 0,0, 0,0,1, 0,1,0, 7'h1B);
    bus_stop();
    chk("R3 stop", 3'd0, 0,0, 0,1,1, 0,0,0, 7'h1B);
    repeat (20) @(negedge clk);
    chk("R10 sticky", 3'd0, 0,0, 0,1,1, 0,0,0, 7'h1B);
    clr_all();
    chk("R10 cleared", 3'd0, 0,0, 0,0,0, 0,0,0, 7'h1B);

    // boot address, read, NACK
    ack_en = 1'b0;
    bus_start(); clr_all();
    bus_byte(8'h35);
    chk("R5 R7 boot nack", 3'd2, 0,0, 0,0,1, 0,1,1, 7'h1B);
    ninth(s);
    chk_val("R7 nack high on ninth", s, 1'b1);
    chk("R8 transmit", 3'd3, 0,1, 0,0,1, 0,1,1, 7'h1B);

    // repeated start then mismatch
    bus_start();
    chk("R2 repeated start", 3'd1, 0,0, 1,0,1, 1,1,1, 7'h1B);
    clr_all();
    ack_en = 1'b1;
    bus_byte(8'h50);
    chk("R9 mismatch", 3'd0, 0,0, 0,0,0, 0,1,1, 7'h1B);
    ninth(s);
    chk_val("R9 no ack", s, 1'b1);
    bus_stop(); clr_all();

    // general call
    bus_start(); clr_all();
    bus_byte(8'h00);
    chk("R6 gc disabled", 3'd0, 0,0, 0,0,0, 0,1,1, 7'h1B);
    ninth(s); bus_stop(); clr_all();
    gc_en = 1'b1;
    bus_start(); clr_all();
    bus_byte(8'h00);
    chk("R6 gc enabled", 3'd2, 1,0, 0,0,1, 0,1,0, 7'h1B);
    ninth(s);
    chk_val("R6 gc ack", s, 1'b0);
    bus_stop(); clr_all();
    gc_en = 1'b0;

    // reprogram address
    @(negedge clk) begin addr_we = 1'b1; addr_wdata = 7'h22; end
    @(negedge clk) addr_we = 1'b0;
    chk("R12 write", 3'd0, 0,0, 0,0,0, 0,0,0, 7'h22);
    bus_start(); clr_all();
    bus_byte(8'h45);
    chk("R12 new address", 3'd2, 1,0, 0,0,1, 0,1,1, 7'h22);
    ninth(s);
    chk("R8 transmit again", 3'd3, 0,1, 0,0,1, 0,1,1, 7'h22);
    bus_stop(); clr_all();
    bus_start(); clr_all();
    bus_byte(8'h36);
    chk("R12 old address", 3'd0, 0,0, 0,0,0, 0,1,1, 7'h22);
    ninth(s); bus_stop(); clr_all();
    bus_start(); clr_all();
    bus_byte(8'h34);
    chk("R5 boot after rewrite", 3'd2, 1,0, 0,0,1, 0,1,0, 7'h22);
    ninth(s); bus_stop(); clr_all();

    // start in the middle of a byte
    bus_start(); clr_all();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    chk("R11 partial byte", 3'd1, 0,0, 0,0,0, 1,1,0, 7'h22);
    bus_start(); clr_all();
    bus_byte(8'h35);
    chk("R11 restarted byte", 3'd2, 1,0, 0,0,1, 0,1,1, 7'h22);
    ninth(s); bus_stop(); clr_all();

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule